// File: doc/BRIEF.md
# Lock-Protected Watchdog Timer with Expiry Escalation

This block is a watchdog timer reached over a simple word-addressed register bus. Every access is a full 32-bit word. A 32-bit down-counter runs while the timer is enabled. When the counter sits at zero it expires, raises a sticky expiry flag and reloads itself from a reload register. The current count can be read at any time but never written. The only ways to load it are a reload command, an expiry, or a forced expiry. Turning the timer on does not load the counter.

The configuration words (control, reload value, trip limit and reload command) are write-protected. A key written to the unlock word opens them, and any other value written there closes them again. A write to a configuration word while it is closed is discarded. Such a write also sets a sticky error flag and forces an immediate expiry. Each expiry is counted. When the count of earlier expiries equals the trip limit, a reset output is raised and held until the hardware reset input is asserted. A separate synchronous system-reset input clears the timer state, but it leaves the trip limit and the reset output alone. This is the input a system feeds from the watchdog's own reset output.

Top module: `wdog_trip_top`

## Requirements
- R1: While enabled and with a nonzero count, the current count (read at word 5) falls by exactly one per clock. Setting the enable bit (bit 0 of word 1) does not load the count from the reload register.
- R2: While enabled with a count of zero, the block expires. On the next clock the expired flag (bit 0 of the status word 6) is set and the count equals the reload value.
- R3: While locked, a write to word 1, 2, 3 or 4 leaves every stored value unchanged, sets the error flag (bit 1 of word 6) and forces an expiry with the effects of R2 and R7.
- R4: Writing 0xAD21AD21 to word 0 unlocks the configuration words. Any other value written to word 0 locks them. Word 0 reads 1 in bit 0 when unlocked and 0 when locked.
- R5: Word 5 is read-only and a write to it changes nothing. A write of any value to word 4 while unlocked copies the reload value into the current count.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R7: Each expiry is counted. An expiry that occurs when the number of earlier expiries equals the trip value (word 3) raises wd_rst_o on the next clock. A trip value of 0 therefore resets on the first expiry.
- R8: wd_rst_o stays high until rst_n is asserted. A low sys_rst_n for one clock clears control, reload, count, lock, status and the expiry count, but keeps wd_rst_o and the trip value.
- R9: wd_err_o equals the error flag at all times.
- R10: Words 1, 2 and 3 read back the last accepted value (word 1 in bit 0 only). Words 4 and 7 read zero. After reset every word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous assert, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low, spares trip value and reset output |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| wd_rst_o | output | 1 | Latched reset request |
| wd_err_o | output | 1 | Error flag output |

## Verification
Reads are combinational, so a read result belongs to the same cycle as its address and is sampled one time unit after the inputs change. Every write, expiry and decrement takes effect at the following clock edge. Status flags and wd_rst_o follow an expiry one edge later, and wd_err_o follows the error flag in the same cycle. The bench steps a reference model once per edge, using the values from before that edge. It compares outputs at the falling edge after each rising edge, so each result is checked in the cycle it is due and never earlier. A released hardware reset takes two more edges to reach the logic. The bench waits with idle cycles in which nothing can change.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_UNLOCK = 3'd0;
  localparam logic [AW-1:0] ADDR_CTRL   = 3'd1;
  localparam logic [AW-1:0] ADDR_RELOAD = 3'd2;
  localparam logic [AW-1:0] ADDR_TRIP   = 3'd3;
  localparam logic [AW-1:0] ADDR_CMD    = 3'd4;
  localparam logic [AW-1:0] ADDR_CUR    = 3'd5;
  localparam logic [AW-1:0] ADDR_STAT   = 3'd6;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'hAD21_AD21;

  localparam int ST_EXP = 0;
  localparam int ST_ERR = 1;
  localparam int ST_W   = 2;

  typedef struct packed {
    logic err;
    logic exp;
  } wdog_flags_t;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock
  import wdog_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic              cfg_we_o,
  output logic              illegal_o
);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

  logic unl_q, unl_d, unl_ce;
  logic cfg_sel;

  always_comb begin
    cfg_sel = wr_i && ((addr_i == ADDR_CTRL) || (addr_i == ADDR_RELOAD) ||
                       (addr_i == ADDR_TRIP) || (addr_i == ADDR_CMD));
  end

  always_comb begin
    unl_ce = 1'b0;
    unl_d  = unl_q;
    if (!sys_rst_n) begin
      unl_ce = 1'b1;
      unl_d  = 1'b0;
    end else if (wr_i && (addr_i == ADDR_UNLOCK)) begin
      unl_ce = 1'b1;
      unl_d  = (wdata_i == KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= 1'b0;
    else if (unl_ce) unl_q <= unl_d;
  end

  assign unlocked_o = unl_q;
  assign cfg_we_o   = sys_rst_n && cfg_sel && unl_q;
  assign illegal_o  = sys_rst_n && cfg_sel && !unl_q;

  // R4: a key write always opens, anything else always closes
  a_r4_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && wr_i && addr_i == ADDR_UNLOCK && wdata_i == KEY) |=> unl_q);
  a_r4_other_locks: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && wr_i && addr_i == ADDR_UNLOCK && wdata_i != KEY) |=> !unl_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = sys_rst_n && (force_i || (en_i && at_zero));

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (!sys_rst_n) begin
      cnt_ce = 1'b1;
      cnt_d  = '0;
    end else if (expire_o || load_i) begin
      cnt_ce = 1'b1;
      cnt_d  = reload_i;
    end else if (en_i) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: one step down per enabled clock
  a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && en_i && !at_zero && !load_i && !force_i) |=> (cnt_q == $past(cnt_q) - ONE));
  // R2 / R5: expiry or command copies the reload value
  a_r2_reload_on_expire: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (expire_o || (sys_rst_n && load_i)) |=> (cnt_q == $past(reload_i)));
  // R1: disabled count holds
  a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && !en_i && !load_i && !force_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_rst_n,
  input  wdog_flags_t     set_i,
  input  logic [ST_W-1:0] clr_i,
  output wdog_flags_t     flags_o
);
  logic [ST_W-1:0] st_q, st_d;

  always_comb begin
    if (!sys_rst_n) st_d = '0;
    else            st_d = (st_q & ~clr_i) | {set_i.err, set_i.exp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign flags_o.exp = st_q[ST_EXP];
  assign flags_o.err = st_q[ST_ERR];

  // R2: expiry leaves a sticky flag
  a_r2_exp_flag_set: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    set_i.exp |=> st_q[ST_EXP]);
  // R3: locked write leaves the error flag
  a_r3_err_flag_set: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    set_i.err |=> st_q[ST_ERR]);
  // R6: a flag only falls through a write of one
  a_r6_sticky_exp: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && st_q[ST_EXP] && !clr_i[ST_EXP]) |=> st_q[ST_EXP]);
  a_r6_clear_exp: assert property (@(posedge clk) disable iff (!rst_n || !sys_rst_n)
    (sys_rst_n && clr_i[ST_EXP] && !set_i.exp) |=> !st_q[ST_EXP]);
endmodule

// File: rtl/wdog_trip.sv
module wdog_trip #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_n,
  input  logic              expire_i,
  input  logic              trip_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] trip_o,
  output logic              rst_req_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(1);

  logic [DATA_W-1:0] trip_q;
  logic [EXP_W-1:0]  exp_q, exp_d;
  logic              exp_ce;
  logic              rst_q, rst_d;
  logic              hit;

  assign hit = (DATA_W'(exp_q) == trip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= '0;
    else if (trip_we_i) trip_q <= wdata_i;
  end

  always_comb begin
    exp_ce = 1'b0;
    exp_d  = exp_q;
    if (!sys_rst_n) begin
      exp_ce = 1'b1;
      exp_d  = '0;
    end else if (expire_i && (exp_q != EXP_MAX)) begin
      exp_ce = 1'b1;
      exp_d  = exp_q + EXP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= '0;
    else if (exp_ce) exp_q <= exp_d;
  end

  always_comb begin
    rst_d = rst_q | (expire_i && hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= rst_d;
  end

  assign trip_o    = trip_q;
  assign rst_req_o = rst_q;

  // R8: once raised the request holds until hardware reset
  a_r8_rst_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  // R8: system reset does not touch the trip value
  a_r8_trip_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_n) |=> $stable(trip_q));
  // R7: limit zero escalates on the first expiry
  a_r7_zero_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && trip_q == '0 && exp_q == '0) |=> rst_q);
endmodule

// File: rtl/wdog_trip_top.sv
module wdog_trip_top
  import wdog_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  parameter int EXP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_rst_o,
  output logic              wd_err_o
);
  localparam int SYNC_D = 2;

  logic [SYNC_D-1:0] rsync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SYNC_D-1];

  logic              unlocked, cfg_we, illegal;
  logic              en_q, en_d, en_ce;
  logic [DATA_W-1:0] rel_q, rel_d;
  logic              rel_ce;
  logic [DATA_W-1:0] cnt;
  logic              expire;
  logic [DATA_W-1:0] trip;
  wdog_flags_t       flags, flag_set;
  logic [ST_W-1:0]   flag_clr;
  logic              load_cmd;

  wdog_lock #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .sys_rst_n(sys_rst_n),
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .unlocked_o(unlocked), .cfg_we_o(cfg_we), .illegal_o(illegal)
  );

  always_comb begin
    en_ce = 1'b0;
    en_d  = en_q;
    if (!sys_rst_n) begin
      en_ce = 1'b1;
      en_d  = 1'b0;
    end else if (cfg_we && bus_addr == ADDR_CTRL) begin
      en_ce = 1'b1;
      en_d  = bus_wdata[0];
    end
  end

  always_comb begin
    rel_ce = 1'b0;
    rel_d  = rel_q;
    if (!sys_rst_n) begin
      rel_ce = 1'b1;
      rel_d  = '0;
    end else if (cfg_we && bus_addr == ADDR_RELOAD) begin
      rel_ce = 1'b1;
      rel_d  = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= 1'b0;
      rel_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (rel_ce) rel_q <= rel_d;
    end
  end

  assign load_cmd = cfg_we && (bus_addr == ADDR_CMD);

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .sys_rst_n(sys_rst_n),
    .en_i(en_q), .load_i(load_cmd), .force_i(illegal),
    .reload_i(rel_q), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_trip #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_trip (
    .clk(clk), .rst_n(rst_int_n), .sys_rst_n(sys_rst_n),
    .expire_i(expire), .trip_we_i(cfg_we && bus_addr == ADDR_TRIP),
    .wdata_i(bus_wdata), .trip_o(trip), .rst_req_o(wd_rst_o)
  );

  always_comb begin
    flag_set.exp = expire;
    flag_set.err = illegal;
    flag_clr     = (bus_wr && bus_addr == ADDR_STAT) ? bus_wdata[ST_W-1:0] : '0;
  end

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .sys_rst_n(sys_rst_n),
    .set_i(flag_set), .clr_i(flag_clr), .flags_o(flags)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_UNLOCK: bus_rdata[0] = unlocked;
      ADDR_CTRL:   bus_rdata[0] = en_q;
      ADDR_RELOAD: bus_rdata    = rel_q;
      ADDR_TRIP:   bus_rdata    = trip;
      ADDR_CUR:    bus_rdata    = cnt;
      ADDR_STAT:   bus_rdata    = DATA_W'({flags.err, flags.exp});
      default:     bus_rdata    = '0;
    endcase
  end

  assign wd_err_o = flags.err;

  // R3: a locked configuration write leaves stored values alone
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_int_n || !sys_rst_n)
    illegal |=> ($stable(rel_q) && $stable(en_q) && $stable(trip)));
  // R5: the count word is not writable
  a_r5_cur_readonly: assert property (@(posedge clk) disable iff (!rst_int_n || !sys_rst_n)
    (sys_rst_n && bus_wr && bus_addr == ADDR_CUR && !en_q) |=> $stable(cnt));
  // R9: error output tracks the status word
  a_r9_err_matches: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wd_err_o == bus_rdata[ST_ERR]) || (bus_addr != ADDR_STAT));
endmodule

// File: tb/wdog_trip_top_tb_top.sv
`timescale 1ns/1ps
module wdog_trip_top_tb_top;
  localparam logic [31:0] KEY = 32'hAD21_AD21;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sys_rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wd_rst_o;
  logic        wd_err_o;

  always #10 clk = ~clk;

  wdog_trip_top dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_rst_o(wd_rst_o), .wd_err_o(wd_err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic        m_unl, m_en, m_rst;
  logic [31:0] m_rel, m_trip, m_cnt, m_exp;
  logic [1:0]  m_st;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'b0, m_unl};
      3'd1: return {31'b0, m_en};
      3'd2: return m_rel;
      3'd3: return m_trip;
      3'd5: return m_cnt;
      3'd6: return {30'b0, m_st};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R4 unlock word";
      3'd5: return "R1 R5 count word";
      3'd6: return "R2 R3 R6 status word";
      default: return "R10 register read";
    endcase
  endfunction

  task automatic m_hw_reset();
    m_unl = 0; m_en = 0; m_rst = 0; m_rel = 0; m_trip = 0;
    m_cnt = 0; m_exp = 0; m_st = 0;
  endtask

  task automatic m_edge(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic sys);
    logic cfg, ill, leg, ex;
    logic [31:0] old_rel;
    if (!sys) begin
      m_unl = 0; m_en = 0; m_rel = 0; m_cnt = 0; m_st = 0; m_exp = 0;
      return;
    end
    cfg = wr && (a >= 3'd1) && (a <= 3'd4);
    ill = cfg && !m_unl;
    leg = cfg && m_unl;
    ex  = ill || (m_en && m_cnt == 0);
    old_rel = m_rel;
    if (ex) begin
      if (m_exp == m_trip) m_rst = 1'b1;
      if (m_exp != 32'hFFFF_FFFF) m_exp = m_exp + 1;
    end
    if (ex || (leg && a == 3'd4)) m_cnt = old_rel;
    else if (m_en) m_cnt = m_cnt - 1;
    if (wr && a == 3'd6) m_st = m_st & ~d[1:0];
    m_st = m_st | {ill, ex};
    if (leg && a == 3'd1) m_en = d[0];
    if (leg && a == 3'd2) m_rel = d;
    if (leg && a == 3'd3) m_trip = d;
    if (wr && a == 3'd0) m_unl = (d == KEY);
  endtask

  // one bus cycle: drive at falling edge, check read, clock, check outputs
  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic sys);
    bus_wr = wr; bus_addr = a; bus_wdata = d; sys_rst_n = sys;
    #1;
    chk(rd_tag(a), bus_rdata, m_read(a));
    @(posedge clk);
    m_edge(wr, a, d, sys);
    @(negedge clk);
    chk("R8 reset output", {31'b0, wd_rst_o}, {31'b0, m_rst});
    chk("R9 error output", {31'b0, wd_err_o}, {31'b0, m_st[1]});
  endtask

  task automatic rd(input logic [2:0] a);
    step(1'b0, a, 32'd0, 1'b1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b1);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; sys_rst_n = 1'b1;
    m_hw_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd(3'd5);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; sys_rst_n = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    hw_reset();

    // R10 reset state of every word
    for (int a = 0; a < 8; a++) rd(3'(a));
    chk("R8 reset output low after reset", {31'b0, wd_rst_o}, 32'd0);

    // R3 / R7: locked write with trip 0 expires and escalates at once
    wr(3'd2, 32'd9);
    chk("R3 error output set", {31'b0, wd_err_o}, 32'd1);
    chk("R7 trip zero resets on first expiry", {31'b0, wd_rst_o}, 32'd1);
    rd(3'd2);
    rd(3'd6);
    // R8 system reset does not release it
    step(1'b0, 3'd6, 32'd0, 1'b0);
    chk("R8 held through system reset", {31'b0, wd_rst_o}, 32'd1);
    hw_reset();
    chk("R8 released by hardware reset", {31'b0, wd_rst_o}, 32'd0);

    // R4 unlock, R1 enable does not load
    wr(3'd0, KEY); rd(3'd0);
    wr(3'd3, 32'd2); wr(3'd2, 32'd4);
    wr(3'd4, 32'd0);                 // R5 reload command
    rd(3'd5);
    wr(3'd1, 32'd1);
    for (int i = 0; i < 6; i++) rd(3'd5);
    wr(3'd5, 32'h1234_5678);         // R5 write to count ignored
    for (int i = 0; i < 14; i++) rd(3'd5);
    wr(3'd6, 32'd3); rd(3'd6);       // R6 clear
    rd(3'd3);
    // R8 trip value survives system reset
    step(1'b0, 3'd3, 32'd0, 1'b0);
    rd(3'd3); rd(3'd0); rd(3'd1);
    // R4 wrong value relocks
    wr(3'd0, KEY); wr(3'd0, 32'h1111_2222); rd(3'd0);
    wr(3'd1, 32'd1); rd(3'd1); rd(3'd6);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [2:0]  a;
      logic [31:0] d;
      logic        w, s;
      r = $urandom % 1000;
      if (r == 0) begin
        hw_reset();
        continue;
      end
      a = 3'($urandom % 8);
      w = ($urandom % 100) < 40;
      s = (r > 6);
      case (a)
        3'd0: d = ($urandom % 4 != 0) ? KEY : $urandom;
        3'd1: d = $urandom;
        3'd2: d = $urandom % 24;
        3'd3: d = $urandom % 8;
        3'd6: d = $urandom % 4;
        default: d = $urandom;
      endcase
      step(w, a, d, s);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule